// File: doc/BRIEF.md
# Change-of-State Digital Input Port

The block samples forty-eight external digital inputs, arranged as six groups of eight, and presents them on a small 8-bit bus. The bus decodes an 8-byte window. Six of the offsets return the synchronized input groups, and one offset holds a control and status register. Software enables change watching per group by writing a mask. Any toggle, rising or falling, on an input in an enabled group latches a change flag for that group and raises an interrupt line.

The interrupt handler reads the status register. The read returns the latched group flags and a pending bit that is low while an interrupt is outstanding. The same read clears the flags, so one status read both reports and acknowledges the interrupt.

Each input passes through a two-stage synchronizer. An edge is detected by comparing the synchronized value with its value one clock earlier. Read data is registered and appears on the cycle after the read strobe.

Top module: `cos_input_port`

## Requirements
- R1: A read at offset 0, 1 or 2 returns group 0, 1 or 2. A read at offset 4, 5 or 6 returns group 3, 4 or 5. Group k carries inputs 8k..8k+7, with input 8k+n in bit n. Read data is valid the cycle after the strobe.
- R2: A read at offset 3 returns 0x00.
- R3: The inputs pass through a two-flop synchronizer. A stable input change is visible on a data read started three clocks after the change.
- R4: A write to offset 7 loads bits 5:0 of the write data as the group enable mask (bit k enables group k). After reset the mask is 0.
- R5: A rising or a falling edge on any input of an enabled group sets that group's change flag.
- R6: An edge in a group whose enable bit is 0 sets no flag and raises no interrupt.
- R7: Once set, a change flag stays set until the status register is read, even when the input returns to its old value.
- R8: A read at offset 7 returns the change flags in bits 5:0. Bit 6 reads 0 when any flag is set and 1 otherwise. Bit 7 reads 0.
- R9: A status read clears all flags, and the interrupt falls at the same clock edge. An edge that is detected in the cycle of that read is kept, and it shows on the next status read.
- R10: The interrupt output is active high and is asserted exactly while any change flag is set.
- R11: Writes to offsets 0 through 6 have no effect on the enable mask or on the flags.
- R12: After reset all flags are 0, the interrupt is low, and a status read returns 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 48 | Asynchronous digital inputs |
| bus_addr | input | 3 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Active-high interrupt |

## Verification
A status read that acknowledges the interrupt can land in the same clock as a new edge in another enabled group. The bench provokes this by toggling the group 1 input so that its detection cycle coincides with the read strobe, while group 0 already holds a flag. That read must report only group 0. The interrupt must then stay asserted, and the following status read must report group 1 alone.

// File: rtl/cos_port_pkg.sv
package cos_port_pkg;
  localparam int DEF_GROUPS  = 6;
  localparam int DEF_GROUP_W = 8;
  localparam int ADDR_W      = 3;
  localparam logic [ADDR_W-1:0] GAP_OFS    = 3'd3;
  localparam logic [ADDR_W-1:0] STATUS_OFS = 3'd7;

  // Byte offset to input group; the gap offset is skipped.
  function automatic int ofs_to_group(input logic [ADDR_W-1:0] ofs);
    return (ofs < GAP_OFS) ? int'(ofs) : int'(ofs) - 1;
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] toggle
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[STAGES-1];
  end

  assign sync_q = stg[STAGES-1];
  assign toggle = stg[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cos_flags.sv
module cos_flags #(
  parameter int GROUPS  = 6,
  parameter int GROUP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [GROUPS*GROUP_W-1:0] toggle,
  input  logic [GROUPS-1:0]         en,
  input  logic                      clr,
  output logic [GROUPS-1:0]         chg,
  output logic [GROUPS-1:0]         flags,
  output logic                      irq
);
  logic [GROUPS-1:0] flags_nx;

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_grp
      assign chg[g] = en[g] & (|toggle[g*GROUP_W +: GROUP_W]);
    end
  endgenerate

  always_comb flags_nx = clr ? chg : (flags | chg);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nx;
      irq   <= |flags_nx;
    end
  end
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_port_pkg::*;
#(
  parameter int GROUPS  = 6,
  parameter int GROUP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd,
  input  logic                      wr,
  input  logic [GROUP_W-1:0]        wdata,
  input  logic [GROUPS*GROUP_W-1:0] sync_q,
  input  logic [GROUPS-1:0]         flags,
  output logic [GROUPS-1:0]         en,
  output logic                      status_rd,
  output logic [GROUP_W-1:0]        rdata
);
  localparam int PEND_BIT = GROUPS;

  logic [GROUP_W-1:0] rd_mux;

  assign status_rd = rd && (addr == STATUS_OFS);

  always_comb begin
    rd_mux = '0;
    if (addr == STATUS_OFS) begin
      rd_mux[GROUPS-1:0] = flags;
      rd_mux[PEND_BIT]   = ~(|flags);
    end else if (addr != GAP_OFS) begin
      for (int g = 0; g < GROUPS; g++)
        if (ofs_to_group(addr) == g) rd_mux = sync_q[g*GROUP_W +: GROUP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      rdata <= '0;
    end else begin
      if (wr && addr == STATUS_OFS) en <= wdata[GROUPS-1:0];
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
  import cos_port_pkg::*;
#(
  parameter int NUM_GROUPS  = DEF_GROUPS,
  parameter int GROUP_W     = DEF_GROUP_W,
  parameter int SYNC_STAGES = 2,
  localparam int IN_W       = NUM_GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IN_W-1:0]    din,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [GROUP_W-1:0] bus_wdata,
  output logic [GROUP_W-1:0] bus_rdata,
  output logic               irq_out
);
  logic [IN_W-1:0]       sync_q;
  logic [IN_W-1:0]       toggle;
  logic [NUM_GROUPS-1:0] grp_en;
  logic [NUM_GROUPS-1:0] grp_chg;
  logic [NUM_GROUPS-1:0] grp_flags;
  logic                  status_rd;

  cos_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(din), .sync_q(sync_q), .toggle(toggle)
  );

  cos_flags #(.GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) flags_i (
    .clk(clk), .rst(rst), .toggle(toggle), .en(grp_en), .clr(status_rd),
    .chg(grp_chg), .flags(grp_flags), .irq(irq_out)
  );

  cos_regs #(.GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) regs_i (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .sync_q(sync_q), .flags(grp_flags), .en(grp_en),
    .status_rd(status_rd), .rdata(bus_rdata)
  );
endmodule

// File: rtl/cos_input_port_chk.sv
module cos_input_port_chk
  import cos_port_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int GROUP_W    = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_rd,
  input logic                  bus_wr,
  input logic [GROUP_W-1:0]    bus_rdata,
  input logic                  irq_out,
  input logic [NUM_GROUPS-1:0] flags,
  input logic [NUM_GROUPS-1:0] chg,
  input logic [NUM_GROUPS-1:0] en
);
  assert_irq_tracks_flags_R10: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|flags));

  assert_disabled_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(en)) == '0));

  assert_flags_latch_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_addr == STATUS_OFS) |=> ((flags & $past(flags)) == $past(flags)));

  assert_clear_keeps_new_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == STATUS_OFS) |=> (flags == $past(chg)));

  assert_status_format_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == STATUS_OFS) |=>
      (bus_rdata[NUM_GROUPS-1:0] == $past(flags)) &&
      (bus_rdata[NUM_GROUPS] == ($past(flags) == '0)) &&
      (bus_rdata[GROUP_W-1] == 1'b0));

  assert_gap_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == GAP_OFS) |=> (bus_rdata == '0));

  assert_data_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == STATUS_OFS) |=> $stable(en));
endmodule

bind cos_input_port cos_input_port_chk #(
  .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .flags(grp_flags), .chg(grp_chg),
  .en(grp_en)
);

// File: tb/cos_input_port_tb.sv
module cos_input_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] din = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  cos_input_port dut_i (
    .clk(clk), .rst(rst), .din(din), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R12 irq after reset", {7'd0, irq_out}, 8'h00);
    bus_read(3'd7, d);
    chk("R12 status after reset", d, 8'h40);
  endtask

  task automatic t_data_map;
    logic [7:0] d;
    logic [2:0] ofs [6] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};
    din = 48'h665544332211;
    wait_cyc(3);
    for (int g = 0; g < 6; g++) begin
      bus_read(ofs[g], d);
      chk("R1 group map", d, 8'(8'h11 * (g + 1)));
    end
    din = 48'hA5_0F_F0_80_01_C3;
    wait_cyc(3);
    for (int g = 0; g < 6; g++) begin
      bus_read(ofs[g], d);
      chk("R1 R3 second pattern", d, din[g*8 +: 8]);
    end
    bus_read(3'd3, d);
    chk("R2 gap offset", d, 8'h00);
    din = '0;
    wait_cyc(4);
  endtask

  task automatic t_sync_latency;
    logic [7:0] d;
    din[40] = 1'b1;
    wait_cyc(3);
    bus_read(3'd6, d);
    chk("R3 latency", d, 8'h01);
    din[40] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    bus_write(3'd7, 8'h3F);
    bus_read(3'd7, d);
    din[13] = 1'b1;
    wait_cyc(4);
    chk("R10 irq on rise", {7'd0, irq_out}, 8'h01);
    bus_read(3'd7, d);
    chk("R5 R8 rise status", d, 8'h02);
    chk("R9 irq cleared", {7'd0, irq_out}, 8'h00);
    din[13] = 1'b0;
    wait_cyc(4);
    bus_read(3'd7, d);
    chk("R5 fall status", d, 8'h02);
    din[47] = 1'b1; din[0] = 1'b1;
    wait_cyc(4);
    bus_read(3'd7, d);
    chk("R5 two groups", d, 8'h21);
    din[47] = 1'b0; din[0] = 1'b0;
    wait_cyc(4);
    bus_read(3'd7, d);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    din[20] = 1'b1;
    wait_cyc(2);
    din[20] = 1'b0;
    wait_cyc(8);
    chk("R7 irq held", {7'd0, irq_out}, 8'h01);
    bus_read(3'd7, d);
    chk("R7 flag held", d, 8'h04);
    bus_read(3'd7, d);
    chk("R9 cleared after read", d, 8'h40);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    bus_write(3'd7, 8'h3E);
    din[3] = 1'b1;
    wait_cyc(4);
    chk("R6 no irq", {7'd0, irq_out}, 8'h00);
    bus_read(3'd7, d);
    chk("R6 no flag", d, 8'h40);
    din[3] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_ignored_write;
    logic [7:0] d;
    bus_write(3'd7, 8'h00);
    for (int a = 0; a < 7; a++) bus_write(3'(a), 8'hFF);
    din[30] = 1'b1;
    wait_cyc(4);
    chk("R11 R4 no irq", {7'd0, irq_out}, 8'h00);
    bus_read(3'd7, d);
    chk("R11 status", d, 8'h40);
    din[30] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_race;
    logic [7:0] d;
    bus_write(3'd7, 8'h03);
    din[1] = 1'b1;
    wait_cyc(4);
    din[9] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_read(3'd7, d);
    chk("R9 race read", d, 8'h01);
    chk("R9 irq kept", {7'd0, irq_out}, 8'h01);
    bus_read(3'd7, d);
    chk("R9 late change kept", d, 8'h02);
    chk("R10 irq low", {7'd0, irq_out}, 8'h00);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_data_map();
    t_sync_latency();
    t_edges();
    t_latch();
    t_disabled();
    t_ignored_write();
    t_race();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule